// File: doc/BRIEF.md
# Opcode Fetch Bus Cycle Sequencer

This block is the bus-facing half of a small 8-bit processor whose low address byte and data byte share one set of pins. On request it runs one opcode fetch machine cycle of four T-states. It presents the fetch address, pulses an address strobe so that external logic can capture the low address byte, releases the shared lines, and lowers an active-low read strobe for the memory to answer. It then loads the returned byte into an instruction register, steps the program counter and raises a one-cycle decode pulse for the downstream decoder.

A start request taken while idle opens a fetch on the next clock. If start is still high when the fourth T-state ends, the next fetch follows with no idle gap, so instructions can be fetched back to back. The three status lines carry a code that tells the rest of the system this is an opcode fetch and not a plain memory read. The program counter starts at a parameter value.

Top module: `ofetch_seq`

## Requirements
- R1: While `rst_n` is low, the outputs go to idle at once: `ale` 0, `rd_n` 1, `ad_oe` 0, `decode` 0, status 000, `pc` equal to PC_RESET, `ir` 0. Leaving reset takes effect after a two-flop synchronizer.
- R2: In idle, a high `start` at a clock edge opens T1. A fetch lasts exactly T1, T2, T3, T4. After T4 the block goes back to idle, unless `start` is high at that edge, in which case it goes straight to T1.
- R3: In T1, `ale` is 1, `ad_oe` is 1, `rd_n` is 1, `addr_hi` is `pc[15:8]` and `ad_out` is `pc[7:0]`. `ale` is high only in T1.
- R4: From T1 to T4 the status lines read {`io_m_n`,`s1`,`s0`} = 0,1,1. In idle they read 0,0,0.
- R5: In T2 and T3, `ale` is 0, `ad_oe` is 0, `rd_n` is 0, and `addr_hi` keeps the high byte of the fetch address. `rd_n` is never low while `ad_oe` is 1.
- R6: `pc` goes up by one at the end of T2, so the new value shows from T3. It wraps from FFFF to 0000 and changes at no other time.
- R7: `ir` loads `ad_in` at the end of T3, shows it from T4, and holds it until the next T3 ends.
- R8: `decode` is 1 only in T4, for one cycle per fetch. In T4, `rd_n` is 1, `ad_oe` is 0 and `ale` is 0.
- R9: `start` has no effect during T1 to T3. The fetch in progress goes on with no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an opcode fetch |
| ad_in | input | 8 | Byte returned on the shared lines by memory |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Low address byte driven onto the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| ale | output | 1 | Address latch strobe, falling edge latches the low byte |
| io_m_n | output | 1 | Status: 0 selects memory space |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Active-low read strobe |
| decode | output | 1 | One-cycle pulse in T4 |
| ir | output | 8 | Latched opcode |
| pc | output | 16 | Program counter |

## Verification
The hardest cases to reach are a fetch that starts straight after another with no idle cycle, and a program counter that wraps past FFFF in the middle of such a chain. The bench sets PC_RESET to FFFE and holds `start` high through three fetches, so the wrap happens inside back-to-back cycles. A bench memory latches the low address on the falling edge of `ale` and answers with a byte derived from that address, so a wrong latched address shows up as a wrong opcode. A reset applied during T2 of a fetch shows that the block abandons the fetch and that the expected-item queue stays consistent afterwards.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;

  typedef struct packed {
    logic io_m_n;
    logic s1;
    logic s0;
  } bus_status_t;

  localparam bus_status_t STAT_OPFETCH = '{io_m_n: 1'b0, s1: 1'b1, s0: 1'b1};
  localparam bus_status_t STAT_IDLE    = '{io_m_n: 1'b0, s1: 1'b0, s0: 1'b0};

endpackage

// File: rtl/ofs_rst_sync.sv
module ofs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shreg[STAGES-1];
endmodule

// File: rtl/ofs_tstate_ctl.sv
module ofs_tstate_ctl
  import ofs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  output tstate_e st,
  output logic    ld_addr,
  output logic    inc_pc,
  output logic    ld_ir
);
  tstate_e st_nxt;

  always_comb begin
    st_nxt = st;
    unique case (st)
      TS_IDLE: if (start) st_nxt = TS_T1;
      TS_T1:   st_nxt = TS_T2;
      TS_T2:   st_nxt = TS_T3;
      TS_T3:   st_nxt = TS_T4;
      TS_T4:   st_nxt = start ? TS_T1 : TS_IDLE;
      default: st_nxt = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= TS_IDLE;
    else        st <= st_nxt;
  end

  assign ld_addr = (st_nxt == TS_T1);
  assign inc_pc  = (st == TS_T2);
  assign ld_ir   = (st == TS_T3);
endmodule

// File: rtl/ofs_datapath.sv
module ofs_datapath #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int unsigned PC_RESET = 'h4080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_addr,
  input  logic              inc_pc,
  input  logic              ld_ir,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir
);
  localparam logic [ADDR_W-1:0] PC_RST_V = PC_RESET[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] PC_ONE   = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] pc_nxt;
  logic [ADDR_W-1:0] fa_nxt;
  logic [DATA_W-1:0] ir_nxt;

  always_comb begin
    pc_nxt = pc + PC_ONE;
    fa_nxt = pc;
    ir_nxt = ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc <= PC_RST_V;
    else if (inc_pc) pc <= pc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fetch_addr <= PC_RST_V;
    else if (ld_addr) fetch_addr <= fa_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir <= '0;
    else if (ld_ir) ir <= ir_nxt;
  end
endmodule

// File: rtl/ofs_bus_drv.sv
module ofs_bus_drv
  import ofs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  tstate_e                  st,
  input  logic [ADDR_W-1:0]        fetch_addr,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic                     ale,
  output bus_status_t              status,
  output logic                     rd_n,
  output logic                     decode
);
  always_comb begin
    ale    = 1'b0;
    ad_oe  = 1'b0;
    rd_n   = 1'b1;
    decode = 1'b0;
    status = STAT_OPFETCH;
    unique case (st)
      TS_T1: begin
        ale   = 1'b1;
        ad_oe = 1'b1;
      end
      TS_T2, TS_T3: rd_n = 1'b0;
      TS_T4:        decode = 1'b1;
      default:      status = STAT_IDLE;
    endcase
  end

  assign addr_hi = fetch_addr[ADDR_W-1:DATA_W];
  assign ad_out  = fetch_addr[DATA_W-1:0];
endmodule

// File: rtl/ofetch_seq.sv
module ofetch_seq
  import ofs_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int unsigned PC_RESET = 'h4080
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic                     ale,
  output logic                     io_m_n,
  output logic                     s1,
  output logic                     s0,
  output logic                     rd_n,
  output logic                     decode,
  output logic [DATA_W-1:0]        ir,
  output logic [ADDR_W-1:0]        pc
);
  logic              rst_n_s;
  tstate_e           st;
  logic              ld_addr;
  logic              inc_pc;
  logic              ld_ir;
  logic [ADDR_W-1:0] fetch_addr;
  bus_status_t       status;

  ofs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ofs_tstate_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start   (start),
    .st      (st),
    .ld_addr (ld_addr),
    .inc_pc  (inc_pc),
    .ld_ir   (ld_ir)
  );

  ofs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_RESET(PC_RESET)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .ld_addr    (ld_addr),
    .inc_pc     (inc_pc),
    .ld_ir      (ld_ir),
    .ad_in      (ad_in),
    .fetch_addr (fetch_addr),
    .pc         (pc),
    .ir         (ir)
  );

  ofs_bus_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .st         (st),
    .fetch_addr (fetch_addr),
    .addr_hi    (addr_hi),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .ale        (ale),
    .status     (status),
    .rd_n       (rd_n),
    .decode     (decode)
  );

  assign io_m_n = status.io_m_n;
  assign s1     = status.s1;
  assign s0     = status.s0;
endmodule

// File: rtl/ofetch_seq_chk.sv
module ofetch_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ad_oe,
  input logic              ale,
  input logic              io_m_n,
  input logic              s1,
  input logic              s0,
  input logic              rd_n,
  input logic              decode,
  input logic [DATA_W-1:0] ir,
  input logic [ADDR_W-1:0] pc
);
  assert_ale_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && rd_n));
  assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || !rd_n || decode) |-> (!io_m_n && s1 && s0));
  assert_read_after_ale_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> !rd_n);
  assert_bus_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad_oe && !rd_n));
  assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |-> (pc == $past(pc) + 1'b1));
  assert_ir_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ir) |-> $past(!rd_n));
  assert_decode_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    decode |=> !decode);
  assert_decode_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> decode);
endmodule

bind ofetch_seq ofetch_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ad_oe  (ad_oe),
  .ale    (ale),
  .io_m_n (io_m_n),
  .s1     (s1),
  .s0     (s0),
  .rd_n   (rd_n),
  .decode (decode),
  .ir     (ir),
  .pc     (pc)
);

// File: tb/ofetch_seq_bench.sv
module ofetch_seq_bench;
  localparam logic [15:0] PC_INIT = 16'hFFFE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  ad_in;
  logic [7:0]  addr_hi, ad_out, ir;
  logic        ad_oe, ale, io_m_n, s1, s0, rd_n, decode;
  logic [15:0] pc;

  int n_tests = 0;
  int n_fail  = 0;
  logic [23:0] exp_q[$];
  logic [7:0]  lat_lo = 8'h00;
  logic [7:0]  last_op = 8'h00;

  always #5 clk = ~clk;

  ofetch_seq #(.PC_RESET(32'(PC_INIT))) u_ofetch_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ad_in(ad_in),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
    .io_m_n(io_m_n), .s1(s1), .s0(s0), .rd_n(rd_n), .decode(decode),
    .ir(ir), .pc(pc)
  );

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  // bench memory: low address latched on the falling edge of ale
  always @(negedge ale) lat_lo <= ad_out;
  assign ad_in = !rd_n ? mem_fn({addr_hi, lat_lo}) : 8'h00;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(ale == 1'b0, {tag, " ale"}, 32'(ale), 0);
    chk(rd_n == 1'b1, {tag, " rd_n"}, 32'(rd_n), 1);
    chk(ad_oe == 1'b0, {tag, " ad_oe"}, 32'(ad_oe), 0);
    chk(decode == 1'b0, {tag, " decode"}, 32'(decode), 0);
    chk({io_m_n, s1, s0} == 3'b000, {tag, " status"}, 32'({io_m_n, s1, s0}), 0);
  endtask

  // one fetch; start must already be high. more=0 drops start in T1.
  task automatic fetch(input logic [15:0] a, input bit more);
    @(negedge clk); // T1
    if (!more) start = 1'b0;
    chk(ale && ad_oe && rd_n, "R3 T1 strobes", 32'({ale, ad_oe, rd_n}), 32'h7);
    chk({addr_hi, ad_out} == a, "R3 T1 address", 32'({addr_hi, ad_out}), 32'(a));
    chk(pc == a, "R3 pc in T1", 32'(pc), 32'(a));
    chk({io_m_n, s1, s0} == 3'b011, "R4 status T1", 32'({io_m_n, s1, s0}), 3);
    exp_q.push_back({a, mem_fn(a)});
    @(negedge clk); // T2
    chk(!ale && !ad_oe && !rd_n, "R5 T2 strobes", 32'({ale, ad_oe, rd_n}), 0);
    chk(addr_hi == a[15:8], "R5 T2 addr_hi", 32'(addr_hi), 32'(a[15:8]));
    chk(pc == a, "R6 pc still old in T2", 32'(pc), 32'(a));
    chk(decode == 1'b0, "R9 no early decode", 32'(decode), 0);
    @(negedge clk); // T3
    chk(!ale && !ad_oe && !rd_n, "R5 T3 strobes", 32'({ale, ad_oe, rd_n}), 0);
    chk(pc == a + 16'd1, "R6 pc stepped in T3", 32'(pc), 32'(a + 16'd1));
    chk({io_m_n, s1, s0} == 3'b011, "R4 status T3", 32'({io_m_n, s1, s0}), 3);
    @(negedge clk); // T4
    chk(decode && rd_n && !ad_oe && !ale, "R8 T4 outputs",
        32'({decode, rd_n, ad_oe, ale}), 32'hC);
    chk({io_m_n, s1, s0} == 3'b011, "R4 status T4", 32'({io_m_n, s1, s0}), 3);
    last_op = mem_fn(a);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && decode) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 decode with no fetch", 32'(decode), 0);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk(ir == e[7:0], "R7 opcode", 32'(ir), 32'(e[7:0]));
        chk(pc == e[23:8] + 16'd1, "R6 pc after fetch", 32'(pc), 32'(e[23:8] + 16'd1));
      end
    end
  end

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    chk(pc == PC_INIT, "R1 reset pc", 32'(pc), 32'(PC_INIT));
    chk(ir == 8'h00, "R1 reset ir", 32'(ir), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R2 idle before start");

    // back-to-back chain across the wrap, start held high (R2, R9)
    start = 1'b1;
    fetch(16'hFFFE, 1'b1);
    fetch(16'hFFFF, 1'b1);
    fetch(16'h0000, 1'b0);
    @(negedge clk);
    chk_idle("R2 idle after chain");
    chk(ir == last_op, "R7 ir held in idle", 32'(ir), 32'(last_op));
    chk(pc == 16'h0001, "R6 wrap result", 32'(pc), 1);

    // single-cycle start pulse
    @(negedge clk);
    start = 1'b1;
    fetch(16'h0001, 1'b0);
    @(negedge clk);
    chk_idle("R2 idle after pulse");

    // reset in the middle of a fetch
    start = 1'b1;
    @(negedge clk); // T1
    start = 1'b0;
    @(negedge clk); // T2
    rst_n = 1'b0;
    #1;
    chk_idle("R1 async reset");
    chk(pc == PC_INIT, "R1 pc after reset", 32'(pc), 32'(PC_INIT));
    chk(ir == 8'h00, "R1 ir after reset", 32'(ir), 0);
    exp_q.delete();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R1 idle after release");

    start = 1'b1;
    fetch(16'hFFFE, 1'b0);
    @(negedge clk);
    chk_idle("R2 final idle");
    chk(exp_q.size() == 0, "R8 every fetch decoded", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule